// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the fetch and execute stages of a small 8-bit microcontroller core and decides when the core takes an interrupt. It keeps its own set of pending hardware sources and a pending reset request. Whenever it is idle and no conditional skip is outstanding, it picks the most urgent request. A reset request always beats hardware sources. Among hardware sources the lowest-numbered pending bit wins.

When the global interrupt enable is set, the block performs the entry. It captures the current word program counter and the stack pointer, then writes the return address onto the byte-wide data stack, one byte per handshake, walking the stack pointer downwards. When the last byte has been written it presents the vector target for the program counter, the updated stack pointer and a pulse that tells the core to clear its global enable. When the enable is clear, the selected request is still consumed, and no entry takes place.

The stack write port is a valid/ready stream. While `stk_valid` is high and `stk_ready` is low, the address and data hold still. A byte counts as written only on a cycle where both are high. The sink may hold `stk_ready` low for any number of cycles, and the sequence simply waits. Every other pin is plain control or status.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_pend` is high and the block is idle, no request is consumed and no entry starts; pending bits keep their values apart from new arrivals.
- R2: A pending reset request is chosen before any hardware source and uses vector number 0, giving `pc_target` = 0.
- R3: Among pending hardware sources the lowest set bit index i wins, and its vector number is i+1.
- R4: `pc_target` equals the vector number times 2 when `LONG_JMP` is 1 (the default), or times 1 when it is 0.
- R5: The return address is written least significant byte first, at stack addresses sp, sp-1, sp-2 in that order. `sp_out` at the load pulse equals the captured sp minus the number of bytes written.
- R6: The number of bytes written is 1 for `PC_W` up to 8, 2 for `PC_W` up to 16, and 3 above that. The default `PC_W` of 22 gives 3 bytes, and bits above the PC width are written as zero.
- R7: `pc_load` and `gie_clr` pulse together for one cycle after the last stack byte is accepted, and `busy` falls on the following cycle.
- R8: With `gie` low, an arbitration still clears the winning request, at one request per idle cycle, without any stack write or load. `irq_req` is low exactly when no request remains pending.
- R9: `busy` is high from the arbitration edge through the load pulse. `stk_valid` is only high while busy, and the stack address and data hold while `stk_valid` is high and `stk_ready` is low.
- R10: A source that is set during an entry sequence stays pending and is served at the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req | input | 1 | Reset request, latched as pending on a high cycle |
| irq_set | input | NUM_SRC | Hardware source set pulses, latched into the pending bits |
| gie | input | 1 | Global interrupt enable from the core |
| skip_pend | input | 1 | Core has a skip outstanding; blocks arbitration |
| pc_in | input | PC_W | Current word program counter, the return address |
| sp_in | input | SP_W | Current stack pointer |
| stk_valid | output | 1 | Stack byte write valid |
| stk_ready | input | 1 | Stack sink accepts the byte |
| stk_addr | output | SP_W | Stack write address |
| stk_data | output | 8 | Stack write byte |
| busy | output | 1 | Entry sequence in progress; core stalls fetch |
| irq_req | output | 1 | Any request (reset or hardware) pending |
| pend_o | output | NUM_SRC | Pending hardware source bits |
| pc_load | output | 1 | Load `pc_target` into the program counter |
| pc_target | output | PC_W | Vector address |
| gie_clr | output | 1 | Clear the global interrupt enable |
| sp_out | output | SP_W | Stack pointer after the pushes, valid with `pc_load` |

## Verification
The bench targets these corner cases:
- **Reset and a hardware source in the same cycle.** A design that ignores reset priority enters at a nonzero vector first.
- **Several sources set at once.** An inverted priority encoder serves them in descending order.
- **Source arriving mid-sequence.** A design that drops it never produces that vector; one that re-arbitrates early breaks the current push.
- **Entry under a random back-pressure pattern.** A port that advances on valid alone writes bytes at skipped addresses or in the wrong order.
- **Skip outstanding.** The pending bits must survive unchanged; a design that arbitrates anyway empties them.
- **Global enable low.** One pending bit must disappear per cycle with no stack traffic; a design that keeps them would later take stale interrupts.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_e;

  // Bytes needed to hold a program counter of the given width.
  function automatic int ret_bytes(input int pc_width);
    if (pc_width > 16) return 3;
    else if (pc_width > 8) return 2;
    else return 1;
  endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  win_oh
);
  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    idx    = '0;
    win_oh = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx    = IW'(i);
        win_oh = N'(1) << i;
      end
    end
    any = |pend;
  end

  always_comb begin
    assert_grant_onehot_R3: assert ($onehot0(win_oh));
  end
endmodule

// File: rtl/irq_stack_push.sv
module irq_stack_push #(
  parameter int PC_W = 22,
  parameter int SP_W = 16,
  parameter int NB   = 3,
  localparam int RW  = NB * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PC_W-1:0] ret_pc,
  input  logic [SP_W-1:0] sp_start,
  output logic            stk_valid,
  input  logic            stk_ready,
  output logic [SP_W-1:0] stk_addr,
  output logic [7:0]      stk_data,
  output logic            done,
  output logic [SP_W-1:0] sp_cur
);
  logic          active_q;
  logic [1:0]    cnt_q;
  logic [RW-1:0] ret_q;
  logic          fire;

  assign fire      = active_q && stk_ready;
  assign done      = fire && (int'(cnt_q) == NB - 1);
  assign stk_valid = active_q;
  assign stk_addr  = sp_cur;
  assign stk_data  = ret_q[int'(cnt_q) * 8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ret_q    <= '0;
      sp_cur   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      ret_q    <= RW'(ret_pc);
      sp_cur   <= sp_start;
    end else if (fire) begin
      sp_cur <= sp_cur - SP_W'(1);
      if (done) active_q <= 1'b0;
      else      cnt_q    <= cnt_q + 2'd1;
    end
  end

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> ($stable(stk_addr) && $stable(stk_data) && stk_valid));
  assert_byte_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid |-> (int'(cnt_q) < NB));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int PC_W     = 22,
  parameter int SP_W     = 16,
  parameter bit LONG_JMP = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_req,
  input  logic [NUM_SRC-1:0] irq_set,
  input  logic               gie,
  input  logic               skip_pend,
  input  logic [PC_W-1:0]    pc_in,
  input  logic [SP_W-1:0]    sp_in,
  output logic               stk_valid,
  input  logic               stk_ready,
  output logic [SP_W-1:0]    stk_addr,
  output logic [7:0]         stk_data,
  output logic               busy,
  output logic               irq_req,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_target,
  output logic               gie_clr,
  output logic [SP_W-1:0]    sp_out
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int VW = $clog2(NUM_SRC + 1);
  localparam int NB = ret_bytes(PC_W);

  seq_state_e         state_q;
  logic [NUM_SRC-1:0] pend_q, win_oh, clr_mask;
  logic               rst_p_q, any_hw, decide, take, push_done;
  logic [IW-1:0]      win_idx;
  logic [VW-1:0]      vec;
  logic [PC_W-1:0]    tgt_d, tgt_q;

  irq_prio_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
    .pend(pend_q), .any(any_hw), .idx(win_idx), .win_oh(win_oh)
  );

  // Arbitration happens only when idle and no skip is outstanding.
  assign decide   = (state_q == ST_IDLE) && !skip_pend && (rst_p_q || any_hw);
  assign take     = decide && gie;
  assign clr_mask = (decide && !rst_p_q) ? win_oh : '0;
  assign vec      = rst_p_q ? '0 : VW'(win_idx) + VW'(1);

  generate
    if (LONG_JMP) begin : g_two_word
      assign tgt_d = PC_W'(vec) << 1;
    end else begin : g_one_word
      assign tgt_d = PC_W'(vec);
    end
  endgenerate

  irq_stack_push #(.PC_W(PC_W), .SP_W(SP_W), .NB(NB)) u_push (
    .clk(clk), .rst_n(rst_n), .start(take), .ret_pc(pc_in), .sp_start(sp_in),
    .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_addr(stk_addr),
    .stk_data(stk_data), .done(push_done), .sp_cur(sp_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      rst_p_q <= 1'b0;
      tgt_q   <= '0;
    end else begin
      pend_q  <= (pend_q & ~clr_mask) | irq_set;
      rst_p_q <= (rst_p_q && !decide) || rst_req;
      unique case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_PUSH;
          tgt_q   <= tgt_d;
        end
        ST_PUSH: if (push_done) state_q <= ST_LOAD;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign pc_load   = (state_q == ST_LOAD);
  assign gie_clr   = (state_q == ST_LOAD);
  assign pc_target = tgt_q;
  assign pend_o    = pend_q;
  assign irq_req   = rst_p_q || any_hw;

  assert_skip_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && skip_pend) |=> (!busy && ((pend_o & ~$past(irq_set)) == $past(pend_o))));
  assert_valid_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid |-> busy);
  assert_busy_ends_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pc_load));
  assert_load_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(stk_valid && stk_ready));
endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int N = 8, PCW = 22, SPW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_req = 1'b0, gie = 1'b0, skip_pend = 1'b0, stk_ready = 1'b0;
  logic [N-1:0] irq_set = '0;
  logic [PCW-1:0] pc_in = '0;
  logic [SPW-1:0] sp_in = '0;
  logic stk_valid, busy, irq_req, pc_load, gie_clr;
  logic [SPW-1:0] stk_addr, sp_out;
  logic [7:0] stk_data;
  logic [N-1:0] pend_o;
  logic [PCW-1:0] pc_target;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_set(irq_set), .gie(gie),
    .skip_pend(skip_pend), .pc_in(pc_in), .sp_in(sp_in), .stk_valid(stk_valid),
    .stk_ready(stk_ready), .stk_addr(stk_addr), .stk_data(stk_data), .busy(busy),
    .irq_req(irq_req), .pend_o(pend_o), .pc_load(pc_load), .pc_target(pc_target),
    .gie_clr(gie_clr), .sp_out(sp_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PCW-1:0] exp_target(input int vnum);
    return PCW'(vnum * 2);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [PCW-1:0] pc, input int k);
    logic [23:0] w;
    w = 24'(pc);
    return w[k*8 +: 8];
  endfunction

  // Waits for one entry, with random back-pressure, and checks it.
  task automatic run_entry(input int vnum, input logic [PCW-1:0] pc, input logic [SPW-1:0] sp,
                           input logic [N-1:0] mid_set);
    int nbytes = 0;
    bit loaded = 1'b0;
    bit injected = (mid_set == '0);
    for (int cyc = 0; cyc < 200 && !loaded; cyc++) begin
      @(negedge clk);
      irq_set = '0;
      if (pc_load) begin
        loaded = 1'b1;
        check(pc_target == exp_target(vnum), "R2/R3/R4 pc_target", pc_target, exp_target(vnum));
        check(gie_clr, "R7 gie_clr with load", gie_clr, 1);
        check(nbytes == 3, "R6 byte count", nbytes, 3);
        check(sp_out == sp - SPW'(3), "R5 sp_out", sp_out, sp - SPW'(3));
        check(!stk_valid, "R9 no write at load", stk_valid, 0);
      end else begin
        if (busy && !injected) begin
          irq_set = mid_set;
          injected = 1'b1;
        end
        stk_ready = 1'($urandom_range(0, 2) != 0);
        #1;
        if (stk_valid && stk_ready) begin
          check(stk_addr == sp - SPW'(nbytes), "R5 stack address", stk_addr, sp - SPW'(nbytes));
          check(stk_data == exp_byte(pc, nbytes), "R5 byte order", stk_data, exp_byte(pc, nbytes));
          nbytes++;
        end
        if (stk_valid) check(busy, "R9 valid implies busy", busy, 1);
      end
    end
    check(loaded, "R7 entry completed", loaded, 1);
    @(negedge clk);
    check(!busy, "R7 busy drops after load", busy, 0);
  endtask

  task automatic pulse_set(input logic [N-1:0] m, input bit rr);
    @(negedge clk);
    irq_set = m;
    rst_req = rr;
    @(negedge clk);
    irq_set = '0;
    rst_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1A5C0DE));
    repeat (3) @(negedge clk);
    check(!busy && !stk_valid && !pc_load && pend_o == 0 && !irq_req, "reset state", pend_o, 0);
    rst_n = 1'b1;
    gie = 1'b1;
    pc_in = 22'h2A1B3C;
    sp_in = 16'h08FF;

    // R2: reset request beats a hardware source set in the same cycle
    pulse_set(8'h24, 1'b1);
    run_entry(0, 22'h2A1B3C, 16'h08FF, '0);
    run_entry(3, 22'h2A1B3C, 16'h08FF, '0);
    run_entry(6, 22'h2A1B3C, 16'h08FF, '0);
    check(!irq_req, "R8 irq_req low when empty", irq_req, 0);

    // R10: bit 1 set while bit 5 is being entered
    pulse_set(8'h20, 1'b0);
    run_entry(6, 22'h2A1B3C, 16'h08FF, 8'h02);
    run_entry(2, 22'h2A1B3C, 16'h08FF, '0);

    // R1: skip outstanding holds everything
    skip_pend = 1'b1;
    pulse_set(8'h81, 1'b0);
    repeat (5) @(negedge clk);
    check(!busy && pend_o == 8'h81, "R1 skip blocks entry", pend_o, 8'h81);
    skip_pend = 1'b0;
    run_entry(1, 22'h2A1B3C, 16'h08FF, '0);
    run_entry(8, 22'h2A1B3C, 16'h08FF, '0);

    // R8: enable low consumes one request per cycle with no entry
    gie = 1'b0;
    @(negedge clk);
    irq_set = 8'hB4;
    @(negedge clk);
    irq_set = '0;
    check(pend_o == 8'hB4 && irq_req, "R8 latched", pend_o, 8'hB4);
    @(negedge clk);
    check(pend_o == 8'hB0, "R8 lowest consumed", pend_o, 8'hB0);
    @(negedge clk);
    check(pend_o == 8'hA0 && !busy && !stk_valid, "R8 next consumed", pend_o, 8'hA0);
    repeat (3) @(negedge clk);
    check(pend_o == 0 && !irq_req && !busy, "R8 drained", pend_o, 0);
    gie = 1'b1;

    // R3/R5: random masks, return addresses and stack pointers
    for (int t = 0; t < 40; t++) begin
      logic [N-1:0] m;
      m = N'($urandom_range(1, 255));
      pc_in = PCW'($urandom);
      sp_in = SPW'($urandom_range(16, 65535));
      pulse_set(m, 1'b0);
      for (int b = 0; b < N; b++)
        if (m[b]) run_entry(b + 1, pc_in, sp_in, '0);
      check(pend_o == 0, "R3 all sources served", pend_o, 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule